// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns step events into winding-enable patterns for a stepper motor. It drives either a three-winding variable-reluctance motor or a four-winding unipolar motor. The unipolar motor can be driven in three styles: single-winding wave drive, two-winding full step, and half step. Each step event moves a sequence index one place through the table of the selected style. A direction input picks forward or backward travel, and the index wraps at either end of the cycle. The four winding enables are decoded from the index and the latched mode. The current index is also an output.

Step events come from one of two sources, chosen by a parameter. The first is the rising edge of an external step pulse. The second is a built-in rate divider, a phase accumulator that turns a steps-per-second value into evenly spaced events from the fixed system clock. The required rate follows steps/s = RPM x steps-per-revolution / 60. For example, a 30-degree reluctance motor needs 12 steps per revolution, so 60 RPM needs 12 steps/s.

Top module: `stepper_phase_seq`

## Requirements
- R1: A synchronous reset sets `idx` to 0 and latches the current `mode`, so with `ena` high the outputs show entry 0 of that mode.
- R2: In mode 0 (reluctance), the cycle has 3 entries. `coil` = 0001, 0010, 0100 for index 0, 1, 2, exactly one winding is on, and `coil[3]` stays 0.
- R3: In mode 1 (wave), the cycle has 4 entries. `coil` = 0001, 0010, 0100, 1000 for index 0..3. The bit order is coil[0]=phase A+, coil[1]=phase B+, coil[2]=phase A-, coil[3]=phase B-.
- R4: In mode 2 (two-winding full step), the cycle has 4 entries: `coil` = 1001, 0011, 0110, 1100 for index 0..3.
- R5: In mode 3 (half step), the cycle has 8 entries: `coil` = 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001 for index 0..7. Even indices drive one winding and odd indices drive two.
- R6: With `dir`=0 a step event adds 1 to the index, and with `dir`=1 it subtracts 1. The index wraps modulo the cycle length in both directions.
- R7: When `mode` differs from the latched mode at a clock edge, `idx` becomes 0 at that edge and the new mode takes effect. This happens whether `ena` is high or low, and it takes priority over a step event.
- R8: While `ena` is low, `coil` is 0000, `idx` holds, and step events are discarded.
- R9: With `USE_DIVIDER`=0 the index moves only at the clock edge that first samples `step_in` high after it was low. It moves at most once per pulse, however long `step_in` stays high.
- R10: With `USE_DIVIDER`=1, `step_in` is ignored. A step event occurs every `CLK_HZ`/`rate_sps` clock cycles (for `rate_sps` < `CLK_HZ`), and `rate_sps`=0 produces no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ena | input | 1 | Drive enable; low blanks the windings and freezes the index |
| dir | input | 1 | 0 = forward, 1 = reverse |
| mode | input | 2 | 0 reluctance, 1 wave, 2 full step, 3 half step |
| step_in | input | 1 | Step pulse; a rising edge requests one step |
| rate_sps | input | RATE_W | Steps per second for the internal divider |
| coil | output | 4 | Winding enables |
| idx | output | 3 | Current sequence index |

## Verification
The bench builds two instances. The first keeps the default `CLK_HZ` with `USE_DIVIDER`=0, so every step comes from the pulse input and edge behaviour, wrap in both directions and mode switches can be scored cycle by cycle. The second uses `CLK_HZ`=1000 and `USE_DIVIDER`=1. This brings the divider's period within a few dozen cycles: a rate of 100 gives one step every 10 clocks, and a rate of 0 can be shown to never step. At the default clock frequency these checks would need millions of cycles.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int RATE_W      = 16,
  parameter bit USE_DIVIDER = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena,
  input  logic              dir,
  input  logic [1:0]        mode,
  input  logic              step_in,
  input  logic [RATE_W-1:0] rate_sps,
  output logic [3:0]        coil,
  output logic [2:0]        idx
);

  localparam int ACC_W = $clog2(CLK_HZ) + 1;
  localparam int SUM_W = ((ACC_W > RATE_W) ? ACC_W : RATE_W) + 1;

  localparam logic [1:0] M_VR   = 2'd0;
  localparam logic [1:0] M_WAVE = 2'd1;
  localparam logic [1:0] M_FULL = 2'd2;
  localparam logic [1:0] M_HALF = 2'd3;

  logic [1:0]       mode_q;
  logic             step_q;
  logic [ACC_W-1:0] acc;
  logic             tick;
  logic [2:0]       last;
  logic [3:0]       pat;
  logic [SUM_W-1:0] acc_nxt;

  wire rise_det = step_in & ~step_q;
  wire step_evt = USE_DIVIDER ? tick : rise_det;
  wire mode_chg = (mode != mode_q);

  assign acc_nxt = SUM_W'(acc) + SUM_W'(rate_sps);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (acc_nxt >= SUM_W'(CLK_HZ)) begin
      acc  <= ACC_W'(acc_nxt - SUM_W'(CLK_HZ));
      tick <= 1'b1;
    end else begin
      acc  <= ACC_W'(acc_nxt);
      tick <= 1'b0;
    end
  end

  always_comb begin
    case (mode_q)
      M_VR:    last = 3'd2;
      M_WAVE:  last = 3'd3;
      M_FULL:  last = 3'd3;
      default: last = 3'd7;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      mode_q <= mode;
      step_q <= 1'b0;
    end else begin
      step_q <= step_in;
      mode_q <= mode;
      if (mode_chg)
        idx <= '0;
      else if (ena && step_evt)
        idx <= dir ? ((idx == 3'd0) ? last : idx - 3'd1)
                   : ((idx == last) ? 3'd0 : idx + 3'd1);
    end
  end

  always_comb begin
    pat = 4'b0000;
    case (mode_q)
      M_VR:   pat = 4'b0001 << idx[1:0];
      M_WAVE: pat = 4'b0001 << idx[1:0];
      M_FULL:
        case (idx[1:0])
          2'd0:    pat = 4'b1001;
          2'd1:    pat = 4'b0011;
          2'd2:    pat = 4'b0110;
          default: pat = 4'b1100;
        endcase
      default:
        if (idx[0])
          pat = (4'b0001 << idx[2:1]) | (4'b0001 << (idx[2:1] + 2'd1));
        else
          pat = 4'b0001 << idx[2:1];
    endcase
  end

  assign coil = ena ? pat : 4'b0000;

  // R7
  mode_rst_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (idx == 3'd0));

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ena && !mode_chg) |=> $stable(idx));

  // R9
  single_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_evt && !mode_chg) |=> $stable(idx));

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= last);

  // R2
  vr_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ena && mode_q == M_VR) |-> ($countones(coil) == 1 && !coil[3]));

  // R5
  half_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (ena && mode_q == M_HALF) |-> ($countones(coil) == (idx[0] ? 2 : 1)));

endmodule

// File: tb/test_stepper_phase_seq.sv
module test_stepper_phase_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ena = 1'b1, dir = 1'b0, step = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] coil;
  logic [2:0] idx;

  logic d_rst = 1'b1, d_step = 1'b0;
  logic [15:0] d_rate = 16'd0;
  logic [3:0] d_coil;
  logic [2:0] d_idx;

  int vectors = 0, miscompares = 0;

  stepper_phase_seq #(.USE_DIVIDER(1'b0)) i_stepper_phase_seq (
    .clk(clk), .rst(rst), .ena(ena), .dir(dir), .mode(mode),
    .step_in(step), .rate_sps(16'd0), .coil(coil), .idx(idx));

  stepper_phase_seq #(.CLK_HZ(1000), .RATE_W(16), .USE_DIVIDER(1'b1)) i_stepper_phase_seq_div (
    .clk(clk), .rst(d_rst), .ena(1'b1), .dir(1'b0), .mode(2'd1),
    .step_in(d_step), .rate_sps(d_rate), .coil(d_coil), .idx(d_idx));

  logic [2:0] q_idx[$];
  logic [3:0] q_coil[$];
  string      q_tag[$];

  int         m_idx = 0;
  logic [1:0] m_mode = 2'd0;
  logic       m_stp = 1'b0;

  function automatic int last_of(logic [1:0] md);
    return (md == 2'd0) ? 2 : (md == 2'd3) ? 7 : 3;
  endfunction

  function automatic logic [3:0] pat_of(logic [1:0] md, int i);
    case (md)
      2'd0: case (i) 0: return 4'b0001; 1: return 4'b0010; default: return 4'b0100; endcase
      2'd1: case (i) 0: return 4'b0001; 1: return 4'b0010; 2: return 4'b0100; default: return 4'b1000; endcase
      2'd2: case (i) 0: return 4'b1001; 1: return 4'b0011; 2: return 4'b0110; default: return 4'b1100; endcase
      default: case (i)
        0: return 4'b0001; 1: return 4'b0011; 2: return 4'b0010; 3: return 4'b0110;
        4: return 4'b0100; 5: return 4'b1100; 6: return 4'b1000; default: return 4'b1001;
      endcase
    endcase
  endfunction

  task automatic drive(input logic r, input logic s, input logic d,
                       input logic [1:0] md, input logic e, input string tag);
    @(negedge clk);
    rst = r; step = s; dir = d; mode = md; ena = e;
    if (r) begin
      m_idx = 0; m_mode = md; m_stp = 1'b0;
    end else begin
      if (md != m_mode) m_idx = 0;
      else if (e && s && !m_stp)
        m_idx = d ? ((m_idx == 0) ? last_of(m_mode) : m_idx - 1)
                  : ((m_idx == last_of(m_mode)) ? 0 : m_idx + 1);
      m_mode = md; m_stp = s;
    end
    q_idx.push_back(3'(m_idx));
    q_coil.push_back(e ? pat_of(m_mode, m_idx) : 4'b0000);
    q_tag.push_back(tag);
  endtask

  task automatic step_n(input int n, input logic d, input logic [1:0] md,
                        input logic e, input string tag);
    for (int k = 0; k < n; k++) begin
      drive(1'b0, 1'b1, d, md, e, tag);
      drive(1'b0, 1'b0, d, md, e, tag);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q_idx.size() > 0) begin
      logic [2:0] ei;
      logic [3:0] ec;
      string t;
      ei = q_idx.pop_front(); ec = q_coil.pop_front(); t = q_tag.pop_front();
      vectors++;
      if (idx !== ei || coil !== ec) begin
        miscompares++;
        $display("FAIL %s: idx=%0d coil=%b expected idx=%0d coil=%b", t, idx, coil, ei, ec);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic period_of(output int cyc);
    logic [2:0] prev;
    cyc = 0;
    prev = d_idx;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      d_step = ~d_step;
      cyc++;
      if (d_idx != prev) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int p;
    drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b1, "R1");
    drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b1, "R1");
    drive(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, "R1");
    step_n(6, 1'b0, 2'd0, 1'b1, "R2");
    step_n(4, 1'b1, 2'd0, 1'b1, "R6");
    drive(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, "R7");
    step_n(5, 1'b0, 2'd1, 1'b1, "R3");
    step_n(3, 1'b1, 2'd1, 1'b1, "R6");
    drive(1'b0, 1'b0, 1'b0, 2'd2, 1'b1, "R7");
    step_n(5, 1'b0, 2'd2, 1'b1, "R4");
    for (int k = 0; k < 4; k++) drive(1'b0, 1'b1, 1'b0, 2'd2, 1'b1, "R9");
    drive(1'b0, 1'b0, 1'b0, 2'd2, 1'b1, "R9");
    step_n(3, 1'b0, 2'd2, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b0, 2'd2, 1'b1, "R8");
    drive(1'b0, 1'b1, 1'b0, 2'd2, 1'b1, "R7");
    drive(1'b0, 1'b0, 1'b0, 2'd3, 1'b0, "R7");
    drive(1'b0, 1'b0, 1'b0, 2'd3, 1'b1, "R7");
    step_n(9, 1'b0, 2'd3, 1'b1, "R5");
    step_n(10, 1'b1, 2'd3, 1'b1, "R6");
    drive(1'b1, 1'b0, 1'b0, 2'd3, 1'b1, "R1");
    drive(1'b0, 1'b0, 1'b0, 2'd3, 1'b1, "R1");
    wait (q_idx.size() == 0);
    @(negedge clk);

    d_rst = 1'b1;
    repeat (2) @(negedge clk);
    d_rst = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      d_step = ~d_step;
      chk(int'(d_idx), 0, "R10 rate 0 with step_in toggling");
    end
    d_rate = 16'd100;
    period_of(p);
    period_of(p);
    chk(p, 10, "R10 period at rate 100");
    period_of(p);
    chk(p, 10, "R10 period at rate 100 again");
    chk(int'(d_coil), int'(pat_of(2'd1, int'(d_idx))), "R10 wave pattern under divider");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule